// File: doc/BRIEF.md
# Processor Presence Bitmap with Hot-Plug Event

This block holds one presence bit per processor slot, 256 slots by default, grouped into 32 bytes. A host reads the map one byte per access through a small byte-wide window. Byte `k` of the window holds the processors whose IDs run from `8k` to `8k+7`, with the lowest ID in bit 0.

Processors come and go through two request channels, plug and unplug. Each channel carries a processor ID. An accepted request sets or clears the matching bit. It also pulses the CPU hot-plug bit of the general-purpose event status vector, so that the interrupt-combining logic next to this block can alert software.

At start-up a boot-load strobe copies the set of processors present at boot into the map. Host write cycles to the window are accepted and then discarded. An ID beyond the map is refused and latches an error flag.

Top module: `cpu_presence_map`

## Requirements
- R1: While `rst_n` is low at a clock edge, the map, `rd_data`, `gpe_sts_set` and `id_err` are all cleared to zero.
- R2: A cycle with `boot_load` high replaces the whole map with `boot_mask` at the next edge. Bit `n` of `boot_mask` is processor ID `n`, so it lands in byte `n/8`, bit `n%8`.
- R3: A plug request (`plug_valid` high) with an ID below 256 sets bit `id%8` of byte `id/8` at the next edge.
- R4: An unplug request (`unplug_valid` high) with an ID below 256 clears bit `id%8` of byte `id/8` at the next edge.
- R5: When a plug and an unplug name the same ID in one cycle, the bit ends cleared. When they name different IDs, both take effect. Requests in a boot-load cycle are applied on top of `boot_mask`.
- R6: In the cycle after any cycle with at least one accepted request, `gpe_sts_set` equals 8'b0000_0100 (only bit 2, CPU hot-plug). Otherwise it is all zero.
- R7: A read cycle (`host_en` high, `host_we` low) loads `rd_data` with the addressed byte at the next edge. `rd_data` holds its value in cycles with no read.
- R8: A read of a byte address of 32 or more returns zero.
- R9: A write cycle (`host_en` and `host_we` high) changes neither the map nor `rd_data`.
- R10: A request with an ID of 256 or more leaves the map unchanged and produces no event pulse. It sets `id_err` at the next edge, and `id_err` then stays high until reset.
- R11: A read in the same cycle as an update of the addressed byte returns the byte as it was before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_load | input | 1 | Load the boot presence set |
| boot_mask | input | 256 | Presence set at boot, bit n = processor n |
| plug_valid | input | 1 | Plug request strobe |
| plug_id | input | 9 | Processor ID to mark present |
| unplug_valid | input | 1 | Unplug request strobe |
| unplug_id | input | 9 | Processor ID to mark absent |
| host_en | input | 1 | Host byte access in this cycle |
| host_we | input | 1 | Access is a write (discarded) |
| host_addr | input | 8 | Byte address in the window |
| rd_data | output | 8 | Byte returned one cycle after a read |
| gpe_sts_set | output | 8 | One-cycle event status set pulse, bit 2 = CPU hot-plug |
| id_err | output | 1 | Sticky flag for an out-of-range request ID |

## Verification
The hardest case to reach from the ports is a same-cycle collision: a plug and an unplug of the same ID, together with a host read of the byte holding that ID. Random IDs almost never collide on their own. The random stimulus therefore forces the unplug ID to equal the plug ID on a fixed share of cycles. It also aims reads at the byte of the plug ID, so that the unplug-wins rule and the read-before-update rule are both exercised many times. Out-of-range IDs make the error flag sticky for the rest of the run, so they are injected only in a late directed section.

// File: rtl/cpu_pm_pkg.sv
// Shared constants for the processor presence bitmap.
// Assumes one 8-bit event status vector in which the CPU hot-plug bit sits at a fixed index.
package cpu_pm_pkg;
    localparam int CPM_BYTE_W    = 8;
    localparam int CPM_GPE_W     = 8;
    localparam int CPM_GPE_HPBIT = 2;
    localparam logic [CPM_GPE_W-1:0] CPM_GPE_HP_MASK = CPM_GPE_W'(1) << CPM_GPE_HPBIT;
endpackage

// File: rtl/cpu_pm_id_decode.sv
// Turns one request (strobe + ID) into a one-hot map mask.
// Assumes IDs at or above MAP_W are illegal: such a request gives an empty mask and raises bad.
module cpu_pm_id_decode #(
    parameter int ID_W  = 9,
    parameter int MAP_W = 256
) (
    input  logic             valid,
    input  logic [ID_W-1:0]  id,
    output logic [MAP_W-1:0] mask,
    output logic             hit,
    output logic             bad
);
    localparam logic [ID_W-1:0]  ID_LIMIT = ID_W'(MAP_W);
    localparam logic [MAP_W-1:0] ONE_HOT  = MAP_W'(1);

    logic in_range;

    // Classify the request and build its one-hot mask.
    always_comb begin
        in_range = (id < ID_LIMIT);
        hit      = valid && in_range;
        bad      = valid && !in_range;
        mask     = hit ? (ONE_HOT << id) : '0;
    end
endmodule

// File: rtl/cpu_pm_bitmap_store.sv
// Presence register: an optional boot load, then set bits, then clear bits.
// Clearing last makes an unplug win over a plug of the same ID.
module cpu_pm_bitmap_store #(
    parameter int MAP_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MAP_W-1:0] load_mask,
    input  logic [MAP_W-1:0] set_mask,
    input  logic [MAP_W-1:0] clr_mask,
    output logic [MAP_W-1:0] map_q
);
    logic [MAP_W-1:0] base;

    // Pick the starting point for this cycle's update.
    always_comb base = load ? load_mask : map_q;

    // Register the updated map; reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= (base | set_mask) & ~clr_mask;
    end
endmodule

// File: rtl/cpu_pm_read_port.sv
// Byte read window over the map with one register stage.
// Addresses outside the window return zero. rd_data holds between reads.
module cpu_pm_read_port #(
    parameter int NUM_BYTES = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_BYTES*cpu_pm_pkg::CPM_BYTE_W-1:0] map,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               addr,
    output logic [cpu_pm_pkg::CPM_BYTE_W-1:0] rd_data
);
    import cpu_pm_pkg::*;
    localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
    localparam logic [ADDR_W-1:0] ADDR_LIMIT = ADDR_W'(NUM_BYTES);

    logic [NUM_BYTES-1:0][CPM_BYTE_W-1:0] bytes;
    logic [CPM_BYTE_W-1:0]                sel_byte;

    // View the flat map as bytes and select the addressed one.
    always_comb begin
        bytes    = map;
        sel_byte = (addr < ADDR_LIMIT) ? bytes[addr[IDX_W-1:0]] : '0;
    end

    // Capture the selected byte on a read cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel_byte;
    end
endmodule

// File: rtl/cpu_presence_map.sv
// Processor presence bitmap with plug/unplug requests, a boot load and a byte read window.
// Assumes requests are single-cycle strobes. Host writes are dropped on purpose.
module cpu_presence_map #(
    parameter int NUM_BYTES = 32,
    parameter int ID_W      = 9,
    parameter int ADDR_W    = 8,
    localparam int MAP_W    = NUM_BYTES * cpu_pm_pkg::CPM_BYTE_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              boot_load,
    input  logic [MAP_W-1:0]                  boot_mask,
    input  logic                              plug_valid,
    input  logic [ID_W-1:0]                   plug_id,
    input  logic                              unplug_valid,
    input  logic [ID_W-1:0]                   unplug_id,
    input  logic                              host_en,
    input  logic                              host_we,
    input  logic [ADDR_W-1:0]                 host_addr,
    output logic [cpu_pm_pkg::CPM_BYTE_W-1:0] rd_data,
    output logic [cpu_pm_pkg::CPM_GPE_W-1:0]  gpe_sts_set,
    output logic                              id_err
);
    import cpu_pm_pkg::*;

    logic [MAP_W-1:0] set_mask, clr_mask, map_q;
    logic             plug_hit, plug_bad, unplug_hit, unplug_bad;
    logic             rd_en;

    cpu_pm_id_decode #(.ID_W(ID_W), .MAP_W(MAP_W)) u_plug_dec (
        .valid(plug_valid), .id(plug_id), .mask(set_mask),
        .hit(plug_hit), .bad(plug_bad)
    );

    cpu_pm_id_decode #(.ID_W(ID_W), .MAP_W(MAP_W)) u_unplug_dec (
        .valid(unplug_valid), .id(unplug_id), .mask(clr_mask),
        .hit(unplug_hit), .bad(unplug_bad)
    );

    cpu_pm_bitmap_store #(.MAP_W(MAP_W)) u_store (
        .clk(clk), .rst_n(rst_n), .load(boot_load), .load_mask(boot_mask),
        .set_mask(set_mask), .clr_mask(clr_mask), .map_q(map_q)
    );

    // A host access is a read only when its write flag is low.
    always_comb rd_en = host_en && !host_we;

    cpu_pm_read_port #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .map(map_q), .rd_en(rd_en),
        .addr(host_addr), .rd_data(rd_data)
    );

    // Pulse the hot-plug event bit once per cycle with an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                       gpe_sts_set <= '0;
        else if (plug_hit || unplug_hit)  gpe_sts_set <= CPM_GPE_HP_MASK;
        else                              gpe_sts_set <= '0;
    end

    // Latch any out-of-range request until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                      id_err <= 1'b0;
        else if (plug_bad || unplug_bad) id_err <= 1'b1;
    end
endmodule

// File: rtl/cpu_presence_map_sva.sv
// Protocol checker for cpu_presence_map, attached with bind below.
module cpu_presence_map_sva #(
    parameter int NUM_BYTES = 32,
    parameter int ID_W      = 9,
    parameter int ADDR_W    = 8,
    localparam int MAP_W    = NUM_BYTES * 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boot_load,
    input logic              plug_valid,
    input logic [ID_W-1:0]   plug_id,
    input logic              unplug_valid,
    input logic [ID_W-1:0]   unplug_id,
    input logic              host_en,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [MAP_W-1:0]  map_q,
    input logic [7:0]        rd_data,
    input logic [7:0]        gpe_sts_set,
    input logic              id_err
);
    localparam int IW = $clog2(MAP_W);
    localparam logic [ID_W-1:0]   LIM  = ID_W'(MAP_W);
    localparam logic [ADDR_W-1:0] ALIM = ADDR_W'(NUM_BYTES);

    logic          plug_ok, unplug_ok, any_bad;
    logic [IW-1:0] plug_idx, unplug_idx;

    // Classify requests independently of the design's decoders.
    always_comb begin
        plug_ok    = plug_valid && (plug_id < LIM);
        unplug_ok  = unplug_valid && (unplug_id < LIM);
        any_bad    = (plug_valid && !(plug_id < LIM)) || (unplug_valid && !(unplug_id < LIM));
        plug_idx   = plug_id[IW-1:0];
        unplug_idx = unplug_id[IW-1:0];
    end

    p_plug_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        plug_ok && !(unplug_ok && unplug_id == plug_id) |=> map_q[$past(plug_idx)]);
    p_unplug_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        unplug_ok |=> !map_q[$past(unplug_idx)]);
    p_gpe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_ok || unplug_ok) |=> gpe_sts_set == 8'b0000_0100);
    p_gpe_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(plug_ok || unplug_ok) |=> gpe_sts_set == 8'h00);
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_en && !host_we) |=> $stable(rd_data));
    p_outside_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_en && !host_we && !(host_addr < ALIM) |=> rd_data == 8'h00);
    p_map_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !plug_ok && !unplug_ok && !boot_load |=> $stable(map_q));
    p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_bad |=> id_err);
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        id_err |=> id_err);
endmodule

bind cpu_presence_map cpu_presence_map_sva #(
    .NUM_BYTES(NUM_BYTES), .ID_W(ID_W), .ADDR_W(ADDR_W)
) u_sva (.*);

// File: tb/cpu_presence_map_bench.sv
module cpu_presence_map_bench;
    localparam int NB = 32;
    localparam int MW = NB * 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          boot_load;
    logic [MW-1:0] boot_mask;
    logic          plug_valid, unplug_valid;
    logic [8:0]    plug_id, unplug_id;
    logic          host_en, host_we;
    logic [7:0]    host_addr;
    logic [7:0]    rd_data, gpe_sts_set;
    logic          id_err;

    int errors = 0;
    int checks = 0;

    logic [MW-1:0] m_map;
    logic [7:0]    m_rd;
    logic [7:0]    m_gpe;
    logic          m_err;

    always #5 clk = ~clk;

    cpu_presence_map u_cpu_presence_map (
        .clk(clk), .rst_n(rst_n), .boot_load(boot_load), .boot_mask(boot_mask),
        .plug_valid(plug_valid), .plug_id(plug_id),
        .unplug_valid(unplug_valid), .unplug_id(unplug_id),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .rd_data(rd_data), .gpe_sts_set(gpe_sts_set), .id_err(id_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input logic [MW-1:0] m, input logic [7:0] a);
        return (a < 8'(NB)) ? m[a*8 +: 8] : 8'h00;
    endfunction

    // Reference model of one clock edge, applied to the current stimulus.
    function automatic void model_step();
        logic pok, uok;
        pok = plug_valid && plug_id < 9'd256;
        uok = unplug_valid && unplug_id < 9'd256;
        if (host_en && !host_we) m_rd = byte_of(m_map, host_addr);
        m_gpe = (pok || uok) ? 8'h04 : 8'h00;
        if ((plug_valid && !pok) || (unplug_valid && !uok)) m_err = 1'b1;
        if (boot_load) m_map = boot_mask;
        if (pok) m_map[plug_id[7:0]] = 1'b1;
        if (uok) m_map[unplug_id[7:0]] = 1'b0;
    endfunction

    task automatic idle();
        boot_load = 0; plug_valid = 0; unplug_valid = 0;
        host_en = 0; host_we = 0;
    endtask

    // One cycle: stimulus is already driven; check all outputs after the edge.
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R7", rd_data, m_rd);
        chk("R6", gpe_sts_set, m_gpe);
        chk("R10", id_err, m_err);
        idle();
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        host_en = 1; host_we = 0; host_addr = a;
        tick();
        chk(req, rd_data, byte_of(m_map, a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [MW-1:0] bm;
        void'($urandom(32'd1234));
        idle(); plug_id = 0; unplug_id = 0; host_addr = 0; boot_mask = '0;
        rst_n = 0;
        m_map = '0; m_rd = 0; m_gpe = 0; m_err = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", rd_data, 0); chk("R1", gpe_sts_set, 0); chk("R1", id_err, 0);
        rst_n = 1;
        rd(8'd0, "R1");
        rd(8'd31, "R1");

        // R2: boot load
        for (int i = 0; i < NB; i++) bm[i*8 +: 8] = 8'($urandom);
        bm[0] = 1'b1; bm[255] = 1'b1;
        boot_load = 1; boot_mask = bm;
        tick();
        for (int a = 0; a < NB; a++) rd(8'(a), "R2");
        chk("R2", {24'd0, byte_of(m_map, 8'd31)} & 32'h80, 32'h80);

        // R3: plug id 42 -> byte 5 bit 2
        plug_valid = 1; plug_id = 9'd42; tick();
        rd(8'd5, "R3");
        chk("R3", rd_data[2], 1'b1);
        // R4: unplug id 255 -> byte 31 bit 7
        unplug_valid = 1; unplug_id = 9'd255; tick();
        rd(8'd31, "R4");
        chk("R4", rd_data[7], 1'b0);

        // R5: same id both ways, unplug wins
        plug_valid = 1; plug_id = 9'd17; unplug_valid = 1; unplug_id = 9'd17; tick();
        chk("R6", gpe_sts_set, 8'h04);
        rd(8'd2, "R5");
        chk("R5", rd_data[1], 1'b0);
        // R5: different ids both apply
        plug_valid = 1; plug_id = 9'd16; unplug_valid = 1; unplug_id = 9'd0; tick();
        rd(8'd2, "R5"); chk("R5", rd_data[0], 1'b1);
        rd(8'd0, "R5"); chk("R5", rd_data[0], 1'b0);

        // R11: read byte 3 while plugging id 24
        unplug_valid = 1; unplug_id = 9'd24; tick();
        host_en = 1; host_addr = 8'd3; plug_valid = 1; plug_id = 9'd24; tick();
        chk("R11", rd_data[0], 1'b0);
        rd(8'd3, "R11"); chk("R11", rd_data[0], 1'b1);

        // R8: outside window
        rd(8'd32, "R8"); chk("R8", rd_data, 8'h00);
        rd(8'd255, "R8");

        // R9: write ignored
        rd(8'd3, "R9");
        host_en = 1; host_we = 1; host_addr = 8'd3; tick();
        chk("R9", rd_data, byte_of(m_map, 8'd3));
        host_en = 1; host_we = 1; host_addr = 8'd9; tick();
        rd(8'd9, "R9");
        // R6: idle gives no pulse
        tick(); chk("R6", gpe_sts_set, 8'h00);

        // Random phase with forced same-ID collisions and targeted reads
        for (int n = 0; n < 4000; n++) begin
            plug_valid   = ($urandom_range(0, 2) != 0);
            plug_id      = 9'($urandom_range(0, 255));
            unplug_valid = ($urandom_range(0, 2) != 0);
            unplug_id    = ($urandom_range(0, 3) == 0) ? plug_id : 9'($urandom_range(0, 255));
            host_en      = ($urandom_range(0, 1) != 0);
            host_we      = ($urandom_range(0, 4) == 0);
            host_addr    = ($urandom_range(0, 1) != 0) ? plug_id[7:0] >> 3
                                                       : 8'($urandom_range(0, 40));
            boot_load    = ($urandom_range(0, 199) == 0);
            boot_mask    = {8{$urandom}};
            tick();
        end
        for (int a = 0; a < NB; a++) rd(8'(a), "R5");

        // R10: out-of-range ids are refused and latch the flag
        bm = m_map;
        plug_valid = 1; plug_id = 9'd256; tick();
        chk("R10", id_err, 1'b1); chk("R10", gpe_sts_set, 8'h00);
        unplug_valid = 1; unplug_id = 9'd511; tick();
        for (int a = 0; a < NB; a++) rd(8'(a), "R10");
        chk("R10", (m_map == bm) ? 1 : 0, 1);
        repeat (5) tick();
        chk("R10", id_err, 1'b1);
        // R1: reset clears the flag and map
        rst_n = 0; @(negedge clk); @(negedge clk);
        m_map = '0; m_rd = 0; m_gpe = 0; m_err = 0;
        chk("R1", id_err, 1'b0); chk("R1", rd_data, 8'h00);
        rst_n = 1;
        rd(8'd5, "R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule